// File: doc/BRIEF.md
# Host Register Port with Endian Byte Lanes

This block is the CPU-facing register port of a communication peripheral. A local processor reaches it with an active-low select, separate active-low read and write strobes, and an 8-bit register address. Several devices can share one select line. Each one compares a 4-bit device address from the bus with its own 4-bit identity, and only the device whose identity matches responds. The responding device drives an acknowledge that is held low for a fixed number of wait cycles and then rises. On a read, the data is valid once the acknowledge is high.

Registers are 1, 2 or 4 bytes wide. The bus can run 8, 16 or 32 bits wide, and a configuration register selects the width. In every mode, active lane k carries the register byte at address + k, and the lane to data-bit mapping follows a byte-order strap. A 4-byte register read or written over an 8-bit port therefore takes four accesses at consecutive addresses. The block also holds a sticky interrupt status register, a 32-bit interrupt mask and an active-low interrupt output.

Top module: `host_reg_port`

## Requirements
- R1: An access is qualified only while `sel_ni` is low, exactly one of `rd_ni`/`wr_ni` is low and `dev_addr_i` equals `dev_id_i`. `ack_oe_o` is high only while the access is qualified, and `data_oe_o` is high only while a qualified read is in progress. An unqualified strobe changes no register.
- R2: `ack_o` is low when a qualified access starts and rises after exactly 2 rising clock edges. It stays high until the access is released. Each access commits its write, or captures its read data, exactly once.
- R3: With the byte-order strap low, active lane k (register byte at address + k) sits on data bits 8k+7:8k.
- R4: With the byte-order strap high, active lane k sits on data bits 31-8k:24-8k. In 8-bit mode the single byte therefore uses bits 31:24.
- R5: Register 0x00 bits 1:0 select the port width: 00 selects 8 bits, 01 selects 16 bits, 10 selects 32 bits and 11 selects 8 bits. The reset value is 00.
- R6: A lane outside the active width, or one whose address + k falls in a different register, reads as zero. An 8-bit register read through a 32-bit port returns zero on the upper three lanes.
- R7: A write updates only the register bytes carried by active lanes within the addressed register. In 8-bit mode a 4-byte register is filled by four single-byte writes.
- R8: The byte-order strap is captured on the first rising edge after reset release, and later changes of the strap are ignored.
- R9: Interrupt status sits at 0x04..0x07, with byte 0 at 0x04 holding bits 7:0. A high bit on `int_src_i` sets the matching status bit, which stays set until the CPU writes a 1 to that bit.
- R10: Interrupt mask sits at 0x08..0x0B and resets to zero. `irq_no` is low exactly when some status bit is set and its mask bit is also set.
- R11: 0x0C..0x0D is a 2-byte read/write register and 0x0E is a 1-byte read/write register. All other unlisted addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Port select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 8 | Register byte address |
| dev_addr_i | input | 4 | Device address presented on the bus |
| dev_id_i | input | 4 | This device's identity |
| big_endian_i | input | 1 | Byte-order strap (1 = big endian) |
| data_i | input | 32 | Write data from CPU |
| data_o | output | 32 | Read data to CPU |
| data_oe_o | output | 1 | Read data drive enable |
| ack_o | output | 1 | Acknowledge level (low = wait) |
| ack_oe_o | output | 1 | Acknowledge drive enable (low = high impedance) |
| int_src_i | input | 32 | Interrupt set pulses |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench sweeps both strap values and all four width codes, writing a distinct pattern to every byte address and reading all addresses back. If the lane placement were mirrored or a lane were shifted, bytes would appear on the wrong bits. If lanes were not confined to one register, a neighbouring register's bytes would leak into the upper lanes or be overwritten.

The strap is flipped after each reset. A design that samples it continuously would return the wrong byte order. Each access checks the acknowledge on both sides of each wait edge, so an off-by-one wait count or a repeated commit is caught. Mismatched-identity and double-strobe accesses check that neither the acknowledge nor a register changes. The interrupt sequence checks that a masked status bit is silent, that enabling the mask pulls the request low, and that a write-one clear releases it.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  typedef enum logic [1:0] {
    PW_8     = 2'b00,
    PW_16    = 2'b01,
    PW_32    = 2'b10,
    PW_8_ALT = 2'b11
  } port_width_e;

  localparam logic [7:0] A_CFG   = 8'h00;
  localparam logic [7:0] A_ISR   = 8'h04;
  localparam logic [7:0] A_IMR   = 8'h08;
  localparam logic [7:0] A_SCR16 = 8'h0C;
  localparam logic [7:0] A_SCR8  = 8'h0E;

  // first byte address of the register that owns byte address a
  function automatic logic [7:0] region_of(input logic [7:0] a);
    if (a[7:2] == A_ISR[7:2] || a[7:2] == A_IMR[7:2]) return {a[7:2], 2'b00};
    if (a[7:1] == A_SCR16[7:1]) return {a[7:1], 1'b0};
    return a;
  endfunction

  function automatic int unsigned lanes_for(input port_width_e pw, input int unsigned max_lanes);
    int unsigned n;
    case (pw)
      PW_16:   n = 2;
      PW_32:   n = 4;
      default: n = 1;
    endcase
    return (n > max_lanes) ? max_lanes : n;
  endfunction

endpackage

// File: rtl/hrp_access_ctrl.sv
module hrp_access_ctrl #(
  parameter int ID_W     = 4,
  parameter int ACK_WAIT = 2,
  localparam int CNT_W   = $clog2(ACK_WAIT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_ni,
  input  logic            rd_ni,
  input  logic            wr_ni,
  input  logic [ID_W-1:0] dev_addr_i,
  input  logic [ID_W-1:0] dev_id_i,
  output logic            ack_o,
  output logic            ack_oe_o,
  output logic            rd_oe_o,
  output logic            commit_rd_o,
  output logic            commit_wr_o
);

  logic             valid;
  logic             commit;
  logic [CNT_W-1:0] cnt_q;

  assign valid = !sel_ni && (rd_ni != wr_ni) && (dev_addr_i == dev_id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (!valid)                       cnt_q <= '0;
    else if (cnt_q != CNT_W'(ACK_WAIT))    cnt_q <= cnt_q + 1'b1;
  end

  // single commit on the edge that ends the wait window
  assign commit      = valid && (cnt_q == CNT_W'(ACK_WAIT - 1));
  assign commit_wr_o = commit && !wr_ni;
  assign commit_rd_o = commit && !rd_ni;
  assign ack_o       = (cnt_q == CNT_W'(ACK_WAIT));
  assign ack_oe_o    = valid;
  assign rd_oe_o     = valid && !rd_ni;

endmodule

// File: rtl/hrp_lane_map.sv
module hrp_lane_map import hrp_pkg::*; #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic [7:0]             addr_i,
  input  port_width_e            pw_i,
  input  logic                   big_i,
  input  logic [DATA_W-1:0]      bus_wr_i,
  input  logic [LANES-1:0][7:0]  rd_bytes_i,
  output logic [LANES-1:0][7:0]  lane_addr_o,
  output logic [LANES-1:0]       lane_en_o,
  output logic [LANES-1:0][7:0]  wr_bytes_o,
  output logic [DATA_W-1:0]      bus_rd_o
);

  int unsigned active;
  always_comb active = lanes_for(pw_i, LANES);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr_o[k] = addr_i + 8'(k);
    assign lane_en_o[k]   = (32'(k) < active) &&
                            (region_of(addr_i + 8'(k)) == region_of(addr_i));
    assign wr_bytes_o[k]  = big_i ? bus_wr_i[(LANES-1-k)*8 +: 8] : bus_wr_i[k*8 +: 8];
  end

  always_comb begin
    bus_rd_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_en_o[k]) begin
        if (big_i) bus_rd_o[(LANES-1-k)*8 +: 8] = rd_bytes_i[k];
        else       bus_rd_o[k*8 +: 8]           = rd_bytes_i[k];
      end
    end
  end

endmodule

// File: rtl/hrp_reg_file.sv
module hrp_reg_file import hrp_pkg::*; #(
  parameter int LANES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [LANES-1:0][7:0] lane_addr_i,
  input  logic [LANES-1:0]      lane_en_i,
  input  logic [LANES-1:0][7:0] wr_bytes_i,
  input  logic [31:0]           int_src_i,
  output logic [LANES-1:0][7:0] rd_bytes_o,
  output port_width_e           pw_o,
  output logic [31:0]           isr_o,
  output logic [31:0]           imr_o
);

  logic [7:0]  cfg_q;
  logic [31:0] isr_q;
  logic [31:0] imr_q;
  logic [15:0] scr16_q;
  logic [7:0]  scr8_q;
  logic [31:0] isr_clr;

  function automatic logic [7:0] rd_byte(input logic [7:0] a);
    case (a)
      8'h00:   return cfg_q;
      8'h04:   return isr_q[7:0];
      8'h05:   return isr_q[15:8];
      8'h06:   return isr_q[23:16];
      8'h07:   return isr_q[31:24];
      8'h08:   return imr_q[7:0];
      8'h09:   return imr_q[15:8];
      8'h0A:   return imr_q[23:16];
      8'h0B:   return imr_q[31:24];
      8'h0C:   return scr16_q[7:0];
      8'h0D:   return scr16_q[15:8];
      8'h0E:   return scr8_q;
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    for (int k = 0; k < LANES; k++) rd_bytes_o[k] = rd_byte(lane_addr_i[k]);
  end

  always_comb begin
    isr_clr = '0;
    for (int k = 0; k < LANES; k++) begin
      if (wr_en_i && lane_en_i[k] && lane_addr_i[k][7:2] == A_ISR[7:2])
        isr_clr[{lane_addr_i[k][1:0], 3'b000} +: 8] = wr_bytes_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      isr_q   <= '0;
      imr_q   <= '0;
      scr16_q <= '0;
      scr8_q  <= '0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | int_src_i;
      for (int k = 0; k < LANES; k++) begin
        if (wr_en_i && lane_en_i[k]) begin
          if (lane_addr_i[k] == A_CFG)
            cfg_q <= wr_bytes_i[k];
          else if (lane_addr_i[k][7:2] == A_IMR[7:2])
            imr_q[{lane_addr_i[k][1:0], 3'b000} +: 8] <= wr_bytes_i[k];
          else if (lane_addr_i[k][7:1] == A_SCR16[7:1])
            scr16_q[{lane_addr_i[k][0], 3'b000} +: 8] <= wr_bytes_i[k];
          else if (lane_addr_i[k] == A_SCR8)
            scr8_q <= wr_bytes_i[k];
        end
      end
    end
  end

  assign pw_o  = port_width_e'(cfg_q[1:0]);
  assign isr_o = isr_q;
  assign imr_o = imr_q;

endmodule

// File: rtl/host_reg_port.sv
module host_reg_port import hrp_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int ID_W     = 4,
  parameter int ACK_WAIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [7:0]        addr_i,
  input  logic [ID_W-1:0]   dev_addr_i,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic              big_endian_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ack_o,
  output logic              ack_oe_o,
  input  logic [31:0]       int_src_i,
  output logic              irq_no
);

  localparam int LANES = DATA_W / 8;

  logic                  strap_done_q;
  logic                  big_q;
  logic                  commit_rd;
  logic                  commit_wr;
  logic [LANES-1:0][7:0] lane_addr;
  logic [LANES-1:0]      lane_en;
  logic [LANES-1:0][7:0] wr_bytes;
  logic [LANES-1:0][7:0] rd_bytes;
  logic [DATA_W-1:0]     bus_rd;
  logic [DATA_W-1:0]     rdata_q;
  port_width_e           pw;
  logic [31:0]           isr_w;
  logic [31:0]           imr_w;

  // strap sampled once, on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_done_q <= 1'b0;
      big_q        <= 1'b0;
    end else if (!strap_done_q) begin
      strap_done_q <= 1'b1;
      big_q        <= big_endian_i;
    end
  end

  hrp_access_ctrl #(.ID_W(ID_W), .ACK_WAIT(ACK_WAIT)) u_access (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_ni      (sel_ni),
    .rd_ni       (rd_ni),
    .wr_ni       (wr_ni),
    .dev_addr_i  (dev_addr_i),
    .dev_id_i    (dev_id_i),
    .ack_o       (ack_o),
    .ack_oe_o    (ack_oe_o),
    .rd_oe_o     (data_oe_o),
    .commit_rd_o (commit_rd),
    .commit_wr_o (commit_wr)
  );

  hrp_lane_map #(.DATA_W(DATA_W)) u_lanes (
    .addr_i      (addr_i),
    .pw_i        (pw),
    .big_i       (big_q),
    .bus_wr_i    (data_i),
    .rd_bytes_i  (rd_bytes),
    .lane_addr_o (lane_addr),
    .lane_en_o   (lane_en),
    .wr_bytes_o  (wr_bytes),
    .bus_rd_o    (bus_rd)
  );

  hrp_reg_file #(.LANES(LANES)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (commit_wr),
    .lane_addr_i (lane_addr),
    .lane_en_i   (lane_en),
    .wr_bytes_i  (wr_bytes),
    .int_src_i   (int_src_i),
    .rd_bytes_o  (rd_bytes),
    .pw_o        (pw),
    .isr_o       (isr_w),
    .imr_o       (imr_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (commit_rd) rdata_q <= bus_rd;
  end

  assign data_o = rdata_q;
  assign irq_no = ~|(isr_w & imr_w);

endmodule

// File: rtl/hrp_checker.sv
module hrp_checker #(
  parameter int ACK_WAIT = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ack_o,
  input logic        ack_oe_o,
  input logic        data_oe_o,
  input logic        irq_no,
  input logic [31:0] isr_i,
  input logic [31:0] imr_i,
  input logic        big_i,
  input logic        strap_done_i,
  input logic        wr_commit_i
);

  int drive_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     drive_cnt_q <= 0;
    else if (!ack_oe_o)              drive_cnt_q <= 0;
    else if (drive_cnt_q < ACK_WAIT) drive_cnt_q <= drive_cnt_q + 1;
  end

  p_data_needs_ack_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> ack_oe_o);

  p_ack_starts_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_oe_o) |-> !ack_o);

  p_ack_wait_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_oe_o |-> (ack_o == (drive_cnt_q >= ACK_WAIT)));

  p_ack_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_oe_o && ack_o) |=> (!ack_oe_o || ack_o));

  p_strap_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done_i |=> $stable(big_i));

  p_isr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_commit_i |=> ((isr_i & $past(isr_i)) == $past(isr_i)));

  p_irq_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_i == 32'h0) |-> irq_no);

endmodule

bind host_reg_port hrp_checker #(.ACK_WAIT(ACK_WAIT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ack_o        (ack_o),
  .ack_oe_o     (ack_oe_o),
  .data_oe_o    (data_oe_o),
  .irq_no       (irq_no),
  .isr_i        (isr_w),
  .imr_i        (imr_w),
  .big_i        (big_q),
  .strap_done_i (strap_done_q),
  .wr_commit_i  (commit_wr)
);

// File: tb/host_reg_port_tb.sv
module host_reg_port_tb;

  localparam logic [3:0] ID = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_n, rd_n, wr_n;
  logic [7:0]  addr;
  logic [3:0]  dev_addr;
  logic        big_pin;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rdata_oe, ack, ack_oe;
  logic [31:0] int_src;
  logic        irq_n;

  always #5 clk = ~clk;

  host_reg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .dev_addr_i(dev_addr), .dev_id_i(ID), .big_endian_i(big_pin),
    .data_i(wdata), .data_o(rdata), .data_oe_o(rdata_oe), .ack_o(ack),
    .ack_oe_o(ack_oe), .int_src_i(int_src), .irq_no(irq_n)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] mdl [256];
  bit cur_big;
  int cur_wb;
  int pat_n = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] b_region(input logic [7:0] a);
    if (a >= 8'h04 && a <= 8'h07) return 8'h04;
    if (a >= 8'h08 && a <= 8'h0B) return 8'h08;
    if (a == 8'h0C || a == 8'h0D) return 8'h0C;
    return a;
  endfunction

  function automatic int lane_pos(input int k);
    return cur_big ? 3 - k : k;
  endfunction

  function automatic logic [31:0] exp_bus(input logic [7:0] a);
    logic [31:0] r = '0;
    for (int k = 0; k < cur_wb; k++) begin
      logic [7:0] ak = a + 8'(k);
      if (b_region(ak) == b_region(a)) r[lane_pos(k)*8 +: 8] = mdl[ak];
    end
    return r;
  endfunction

  function automatic logic [31:0] pack32(input logic [31:0] v);
    return cur_big ? {v[7:0], v[15:8], v[23:16], v[31:24]} : v;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] wd);
    for (int k = 0; k < cur_wb; k++) begin
      logic [7:0] ak = a + 8'(k);
      logic [7:0] b  = wd[lane_pos(k)*8 +: 8];
      if (b_region(ak) == b_region(a)) begin
        if (ak >= 8'h04 && ak <= 8'h07) mdl[ak] = mdl[ak] & ~b;
        else if (ak == 8'h00 || (ak >= 8'h08 && ak <= 8'h0E)) mdl[ak] = b;
      end
    end
    case (mdl[0][1:0])
      2'b01:   cur_wb = 2;
      2'b10:   cur_wb = 4;
      default: cur_wb = 1;
    endcase
  endtask

  task automatic access(input bit is_wr, input logic [7:0] a, input logic [31:0] wd,
                        output logic [31:0] rdv);
    @(negedge clk);
    addr = a; wdata = wd; dev_addr = ID; sel_n = 0; rd_n = is_wr; wr_n = !is_wr;
    #1;
    chk("R1 ack driven on qualified access", 32'(ack_oe), 1);
    chk("R2 ack low at start", 32'(ack), 0);
    @(negedge clk);
    chk("R2 ack low after first edge", 32'(ack), 0);
    @(negedge clk);
    chk("R2 ack high after second edge", 32'(ack), 1);
    chk("R1 data drive only on read", 32'(rdata_oe), 32'(!is_wr));
    rdv = rdata;
    sel_n = 1; rd_n = 1; wr_n = 1;
    #1;
    chk("R1 drivers released", {30'b0, ack_oe, rdata_oe}, 0);
    if (is_wr) model_write(a, wd);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] unused_v;
    access(1'b1, a, wd, unused_v);
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    logic [31:0] v;
    access(1'b0, a, 32'h0, v);
    chk(tag, v, exp_bus(a));
  endtask

  task automatic set_width(input logic [1:0] code);
    do_write(8'h00, cur_big ? {6'b0, code, 24'h0} : {30'b0, code});
  endtask

  task automatic do_reset(input bit e);
    rst_n = 0; big_pin = e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    big_pin = !e;  // R8: later strap changes must be ignored
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    cur_big = e; cur_wb = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    sel_n = 1; rd_n = 1; wr_n = 1; addr = 0; dev_addr = ID; wdata = 0;
    int_src = 0; big_pin = 0; rst_n = 0;

    for (int e = 0; e < 2; e++) begin
      do_reset(e[0]);
      chk("R10 irq idle after reset", 32'(irq_n), 1);
      chk("R1 ack released after reset", 32'(ack_oe), 0);
      do_read(8'h08, "R10 mask resets to zero");
      do_read(8'h00, "R5 width code resets to 8-bit");

      for (int w = 0; w < 4; w++) begin
        set_width(w[1:0]);
        for (int a = 4; a < 16; a++) begin
          pat_n++;
          do_write(8'(a), (32'h9E3779B9 * pat_n) ^ {4{8'(a)}});
        end
        for (int a = 0; a < 16; a++)
          do_read(8'(a), e ? "R4 R5 R6 R7 R11 big-endian read" : "R3 R5 R6 R7 R11 little-endian read");
      end

      // R7: four byte writes in 8-bit mode, checked as one 32-bit read
      set_width(2'b00);
      for (int a = 8; a < 12; a++) do_write(8'(a), {4{8'(8'h30 + a)}});
      set_width(2'b10);
      do_read(8'h08, "R7 four 8-bit writes assemble a 4-byte register");

      // R6: 1-byte register through a 32-bit port
      begin
        logic [31:0] v;
        access(1'b0, 8'h0E, 32'h0, v);
        chk("R6 upper lanes zero for 1-byte register",
            cur_big ? {8'h0, v[23:0]} : {v[31:8], 8'h0}, 32'h0);
      end
    end

    // R1: identity mismatch and double strobe are ignored
    @(negedge clk);
    addr = 8'h0C; wdata = 32'hFFFF_FFFF; dev_addr = ID ^ 4'h1; sel_n = 0; wr_n = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 no ack on identity mismatch", 32'(ack_oe), 0);
    end
    sel_n = 1; wr_n = 1; dev_addr = ID;
    @(negedge clk);
    sel_n = 0; rd_n = 0; wr_n = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 no ack with both strobes low", 32'(ack_oe), 0);
    end
    sel_n = 1; rd_n = 1; wr_n = 1;
    do_read(8'h0C, "R1 register unchanged by unqualified strobe");

    // R9 / R10 interrupt path (32-bit, big endian)
    do_write(8'h08, 32'h0);
    @(negedge clk); int_src = 32'h0000_0100;
    @(negedge clk); int_src = 32'h0;
    @(negedge clk);
    chk("R10 masked status keeps irq high", 32'(irq_n), 1);
    mdl[5] = mdl[5] | 8'h01;
    do_read(8'h04, "R9 status bit sticky after pulse");
    do_write(8'h08, pack32(32'h8000_0000));
    chk("R10 other mask bit keeps irq high", 32'(irq_n), 1);
    do_write(8'h08, pack32(32'h0000_0100));
    chk("R10 enabled status drives irq low", 32'(irq_n), 0);
    do_write(8'h04, pack32(32'h0000_0200));
    chk("R9 write of 1 to other bit leaves status", 32'(irq_n), 0);
    do_write(8'h04, pack32(32'h0000_0100));
    chk("R9 write-one clear releases irq", 32'(irq_n), 1);
    do_read(8'h04, "R9 status cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule